// File: doc/BRIEF.md
# Register Result Status Table

This block sits beside the floating-point register file of an out-of-order core that schedules with reservation stations. It holds the 64-bit value of each of 16 architectural registers. Each register also carries a producer tag. The tag names the station whose pending result will next be written there. A tag of zero means no write is pending.

When an instruction issues, the block reads its two source registers at once. For each source it returns either the stored value with a zero tag, or the non-zero tag of the station that will produce the value. In the same cycle it records the issuing station's tag against the destination register. A newer writer replaces an older pending one, so renaming comes from pointing registers at stations rather than from extra physical registers.

The block also watches the shared result broadcast. A broadcast writes its data only into registers whose recorded tag equals the broadcast tag, and those tags are then cleared. A result from a producer that has since been replaced is therefore dropped.

Top module: `reg_status_table`

## Requirements
- R1: While reset is asserted, every register tag is cleared to zero and every stored value to zero. After reset, any source read returns tag 0 and value 0.
- R2: A source register with tag 0 returns its stored value on the value output and 0 on the tag output, in the same cycle as the read.
- R3: A source register with a pending producer returns that producer's non-zero tag on the tag output, in the same cycle as the read.
- R4: An issue (issueValid=1) writes issueTag into the tag of register issueDest at the next rising edge, replacing any older pending tag.
- R5: A broadcast (bcastValid=1, bcastTag non-zero) whose tag equals a register's tag writes bcastData into that register at the next rising edge and clears that tag to 0.
- R6: A broadcast changes nothing when any one of these holds: its tag matches no register tag (for example, a replaced producer), bcastValid is 0, or bcastTag is 0.
- R7: One broadcast updates every register whose tag equals the broadcast tag.
- R8: If an issue names register d as destination in the same cycle that a matching broadcast arrives for d, the issue's tag is what d holds afterwards.
- R9: A source read in the same cycle as a matching broadcast for that register returns bcastData with tag 0.
- R10: A source read in the same cycle as an issue that writes the same register returns the state from before that issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| issueValid | input | 1 | An instruction issues this cycle |
| issueDest | input | 4 | Destination register of the issuing instruction |
| issueTag | input | 4 | Non-zero station tag of the issuing instruction |
| srcA | input | 4 | First source register index |
| srcB | input | 4 | Second source register index |
| bcastValid | input | 1 | A result is broadcast this cycle |
| bcastTag | input | 4 | Tag of the station broadcasting (0 never matches) |
| bcastData | input | 64 | Broadcast result value |
| srcATag | output | 4 | Producer tag for srcA, 0 when the value is ready |
| srcAValue | output | 64 | Value for srcA, meaningful when srcATag is 0 |
| srcBTag | output | 4 | Producer tag for srcB, 0 when the value is ready |
| srcBValue | output | 64 | Value for srcB, meaningful when srcBTag is 0 |

## Verification
Source reads, including the broadcast forwarding path, are combinational and are due in the same cycle their inputs are applied. Tag and value updates from an issue or a broadcast show one rising edge later, on a read of that register. The bench therefore applies each stimulus row on a falling edge and checks the read outputs 1 ns later, before the next rising edge. Each row checks the state that the previous row's edge produced, so every update is observed exactly one cycle after its cause.

// File: rtl/regstat_pkg.sv
package regstat_pkg;

  localparam int unsigned REGSTAT_REGS   = 16;
  localparam int unsigned REGSTAT_DATA_W = 64;
  localparam int unsigned REGSTAT_TAG_W  = 4;

  // Strobes handed from the tag control to the value datapath.
  typedef struct packed {
    logic fwdA;   // srcA takes the broadcast data this cycle
    logic fwdB;   // srcB takes the broadcast data this cycle
  } strobes_t;

endpackage

// File: rtl/regstat_ctrl.sv
module regstat_ctrl #(
  parameter int unsigned NUM_REGS = regstat_pkg::REGSTAT_REGS,
  parameter int unsigned TAG_W    = regstat_pkg::REGSTAT_TAG_W,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   issueValid,
  input  logic [IDX_W-1:0]       issueDest,
  input  logic [TAG_W-1:0]       issueTag,
  input  logic [IDX_W-1:0]       srcA,
  input  logic [IDX_W-1:0]       srcB,
  input  logic                   bcastValid,
  input  logic [TAG_W-1:0]       bcastTag,
  output logic [TAG_W-1:0]       srcATag,
  output logic [TAG_W-1:0]       srcBTag,
  output logic [NUM_REGS-1:0]    valWe,
  output regstat_pkg::strobes_t  strobes
);

  logic [TAG_W-1:0] tagQ [NUM_REGS];
  logic             bcastLive;
  logic [TAG_W-1:0] rawA;
  logic [TAG_W-1:0] rawB;

  // A zero tag means "blank" and can never match.
  assign bcastLive = bcastValid && (bcastTag != '0);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_tag
    logic destHit;
    assign destHit  = issueValid && (issueDest == IDX_W'(i));
    assign valWe[i] = bcastLive && (tagQ[i] == bcastTag);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        tagQ[i] <= '0;
      end else if (destHit) begin
        tagQ[i] <= issueTag;         // newest writer wins
      end else if (valWe[i]) begin
        tagQ[i] <= '0;               // result arrived
      end
    end
  end

  assign rawA = tagQ[srcA];
  assign rawB = tagQ[srcB];

  always_comb begin
    strobes      = '0;
    strobes.fwdA = bcastLive && (rawA == bcastTag);
    strobes.fwdB = bcastLive && (rawB == bcastTag);
    srcATag      = strobes.fwdA ? '0 : rawA;
    srcBTag      = strobes.fwdB ? '0 : rawB;
  end

endmodule

// File: rtl/regstat_data.sv
module regstat_data #(
  parameter int unsigned NUM_REGS = regstat_pkg::REGSTAT_REGS,
  parameter int unsigned DATA_W   = regstat_pkg::REGSTAT_DATA_W,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_REGS-1:0]   valWe,
  input  logic [DATA_W-1:0]     bcastData,
  input  logic [IDX_W-1:0]      srcA,
  input  logic [IDX_W-1:0]      srcB,
  input  regstat_pkg::strobes_t strobes,
  output logic [DATA_W-1:0]     srcAValue,
  output logic [DATA_W-1:0]     srcBValue
);

  logic [DATA_W-1:0] valQ [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_val
    always_ff @(posedge clk) begin
      if (!rstN) begin
        valQ[i] <= '0;
      end else if (valWe[i]) begin
        valQ[i] <= bcastData;
      end
    end
  end

  assign srcAValue = strobes.fwdA ? bcastData : valQ[srcA];
  assign srcBValue = strobes.fwdB ? bcastData : valQ[srcB];

endmodule

// File: rtl/reg_status_table.sv
module reg_status_table #(
  parameter int unsigned NUM_REGS = regstat_pkg::REGSTAT_REGS,
  parameter int unsigned DATA_W   = regstat_pkg::REGSTAT_DATA_W,
  parameter int unsigned TAG_W    = regstat_pkg::REGSTAT_TAG_W,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [IDX_W-1:0]  issueDest,
  input  logic [TAG_W-1:0]  issueTag,
  input  logic [IDX_W-1:0]  srcA,
  input  logic [IDX_W-1:0]  srcB,
  input  logic              bcastValid,
  input  logic [TAG_W-1:0]  bcastTag,
  input  logic [DATA_W-1:0] bcastData,
  output logic [TAG_W-1:0]  srcATag,
  output logic [DATA_W-1:0] srcAValue,
  output logic [TAG_W-1:0]  srcBTag,
  output logic [DATA_W-1:0] srcBValue
);

  logic [NUM_REGS-1:0]   valWe;
  regstat_pkg::strobes_t strobes;

  regstat_ctrl #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .issueDest  (issueDest),
    .issueTag   (issueTag),
    .srcA       (srcA),
    .srcB       (srcB),
    .bcastValid (bcastValid),
    .bcastTag   (bcastTag),
    .srcATag    (srcATag),
    .srcBTag    (srcBTag),
    .valWe      (valWe),
    .strobes    (strobes)
  );

  regstat_data #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .valWe     (valWe),
    .bcastData (bcastData),
    .srcA      (srcA),
    .srcB      (srcB),
    .strobes   (strobes),
    .srcAValue (srcAValue),
    .srcBValue (srcBValue)
  );

endmodule

// File: rtl/reg_status_table_checker.sv
module reg_status_table_checker #(
  parameter int unsigned NUM_REGS = regstat_pkg::REGSTAT_REGS,
  parameter int unsigned DATA_W   = regstat_pkg::REGSTAT_DATA_W,
  parameter int unsigned TAG_W    = regstat_pkg::REGSTAT_TAG_W,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              issueValid,
  input logic [IDX_W-1:0]  issueDest,
  input logic [TAG_W-1:0]  issueTag,
  input logic [IDX_W-1:0]  srcA,
  input logic [IDX_W-1:0]  srcB,
  input logic              bcastValid,
  input logic [TAG_W-1:0]  bcastTag,
  input logic [DATA_W-1:0] bcastData,
  input logic [TAG_W-1:0]  srcATag,
  input logic [DATA_W-1:0] srcAValue,
  input logic [TAG_W-1:0]  srcBTag,
  input logic [DATA_W-1:0] srcBValue
);

  AST_FWD_CLEARS_A: assert property (@(posedge clk) disable iff (!rstN)
    (bcastValid && bcastTag != '0) |-> (srcATag != bcastTag)); // R9

  AST_FWD_CLEARS_B: assert property (@(posedge clk) disable iff (!rstN)
    (bcastValid && bcastTag != '0) |-> (srcBTag != bcastTag)); // R9

  AST_ISSUE_RECORDS: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueTag != '0) |=>
      ((srcA != $past(issueDest)) || (bcastValid && bcastTag == $past(issueTag))
       || (srcATag == $past(issueTag)))); // R4

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!issueValid && srcATag == '0) |=>
      ((srcA != $past(srcA)) || (srcATag == '0 && srcAValue == $past(srcAValue)))); // R5

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!issueValid && !bcastValid) |=>
      ((srcA != $past(srcA)) || bcastValid ||
       (srcATag == $past(srcATag) && srcAValue == $past(srcAValue)))); // R6

endmodule

bind reg_status_table reg_status_table_checker #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)
) u_checker (.*);

// File: tb/reg_status_table_test.sv
module reg_status_table_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [3:0]  issueDest = '0;
  logic [3:0]  issueTag = '0;
  logic [3:0]  srcA = '0;
  logic [3:0]  srcB = '0;
  logic        bcastValid = 1'b0;
  logic [3:0]  bcastTag = '0;
  logic [63:0] bcastData = '0;
  logic [3:0]  srcATag;
  logic [63:0] srcAValue;
  logic [3:0]  srcBTag;
  logic [63:0] srcBValue;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  reg_status_table uut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueDest(issueDest),
    .issueTag(issueTag), .srcA(srcA), .srcB(srcB), .bcastValid(bcastValid),
    .bcastTag(bcastTag), .bcastData(bcastData), .srcATag(srcATag),
    .srcAValue(srcAValue), .srcBTag(srcBTag), .srcBValue(srcBValue)
  );

  typedef struct packed {
    logic        iv;
    logic [3:0]  dest;
    logic [3:0]  tag;
    logic        bv;
    logic [3:0]  btag;
    logic [63:0] bdata;
    logic [3:0]  a;
    logic [3:0]  b;
    logic [3:0]  eaTag;
    logic [63:0] eaVal;
    logic [3:0]  ebTag;
    logic [63:0] ebVal;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  // Outputs of each row reflect state left by the previous rows' edges.
  localparam vec_t VECS [NV] = '{
    '{1'b0,4'd0,4'd0,1'b0,4'd0,64'h0,    4'd1,4'd2,4'd0,64'h0,   4'd0,64'h0,   8'd1},  // R1 blank
    '{1'b1,4'd1,4'd3,1'b0,4'd0,64'h0,    4'd1,4'd1,4'd0,64'h0,   4'd0,64'h0,   8'd10}, // R10
    '{1'b1,4'd2,4'd5,1'b0,4'd0,64'h0,    4'd1,4'd2,4'd3,64'h0,   4'd0,64'h0,   8'd3},  // R3
    '{1'b0,4'd0,4'd0,1'b1,4'd3,64'h1111, 4'd1,4'd2,4'd0,64'h1111,4'd5,64'h0,   8'd9},  // R9
    '{1'b0,4'd0,4'd0,1'b0,4'd0,64'h0,    4'd1,4'd2,4'd0,64'h1111,4'd5,64'h0,   8'd5},  // R5
    '{1'b1,4'd2,4'd6,1'b0,4'd0,64'h0,    4'd2,4'd2,4'd5,64'h0,   4'd5,64'h0,   8'd4},  // R4 override
    '{1'b0,4'd0,4'd0,1'b1,4'd5,64'h2222, 4'd2,4'd1,4'd6,64'h0,   4'd0,64'h1111,8'd6},  // R6 stale
    '{1'b0,4'd0,4'd0,1'b1,4'd3,64'h9999, 4'd1,4'd2,4'd0,64'h1111,4'd6,64'h0,   8'd6},  // R6
    '{1'b0,4'd0,4'd0,1'b0,4'd0,64'h0,    4'd1,4'd2,4'd0,64'h1111,4'd6,64'h0,   8'd6},  // R6
    '{1'b1,4'd4,4'd7,1'b0,4'd6,64'hdead, 4'd2,4'd4,4'd6,64'h0,   4'd0,64'h0,   8'd6},  // R6 invalid
    '{1'b1,4'd5,4'd7,1'b0,4'd0,64'h0,    4'd4,4'd5,4'd7,64'h0,   4'd0,64'h0,   8'd4},  // R4
    '{1'b0,4'd0,4'd0,1'b1,4'd7,64'h7777, 4'd4,4'd5,4'd0,64'h7777,4'd0,64'h7777,8'd7},  // R7
    '{1'b0,4'd0,4'd0,1'b0,4'd0,64'h0,    4'd4,4'd5,4'd0,64'h7777,4'd0,64'h7777,8'd7},  // R7
    '{1'b1,4'd2,4'd8,1'b1,4'd6,64'h6666, 4'd2,4'd2,4'd0,64'h6666,4'd0,64'h6666,8'd8},  // R8
    '{1'b0,4'd0,4'd0,1'b0,4'd0,64'h0,    4'd2,4'd2,4'd8,64'h0,   4'd8,64'h0,   8'd8},  // R8
    '{1'b0,4'd0,4'd0,1'b1,4'd8,64'h8888, 4'd2,4'd3,4'd0,64'h8888,4'd0,64'h0,   8'd5},  // R5
    '{1'b0,4'd0,4'd0,1'b0,4'd0,64'h0,    4'd2,4'd3,4'd0,64'h8888,4'd0,64'h0,   8'd2},  // R2
    '{1'b0,4'd0,4'd0,1'b1,4'd0,64'hdead, 4'd3,4'd0,4'd0,64'h0,   4'd0,64'h0,   8'd6},  // R6 tag 0
    '{1'b0,4'd0,4'd0,1'b0,4'd0,64'h0,    4'd3,4'd0,4'd0,64'h0,   4'd0,64'h0,   8'd6}   // R6
  };

  task automatic checkPort(input string what, input int req,
                           input logic [3:0] tAct, input logic [3:0] tExp,
                           input logic [63:0] vAct, input logic [63:0] vExp);
    total++;
    if (tAct !== tExp || (tExp == 4'd0 && vAct !== vExp)) begin
      bad++;
      $display("FAIL R%0d %s: tag=%0d value=%h expected tag=%0d value=%h",
               req, what, tAct, vAct, tExp, vExp);
    end
  endtask

  task automatic idle();
    issueValid = 1'b0; issueDest = '0; issueTag = '0;
    bcastValid = 1'b0; bcastTag = '0; bcastData = '0;
  endtask

  initial begin
    #80000;
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: every register blank and zero after reset
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      srcA = 4'(r); srcB = 4'(15 - r);
      #1;
      checkPort("reset srcA", 1, srcATag, 4'd0, srcAValue, 64'h0);
    end

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      issueValid = VECS[i].iv;  issueDest = VECS[i].dest; issueTag = VECS[i].tag;
      bcastValid = VECS[i].bv;  bcastTag = VECS[i].btag;  bcastData = VECS[i].bdata;
      srcA = VECS[i].a; srcB = VECS[i].b;
      #1;
      checkPort("row srcA", int'(VECS[i].req), srcATag, VECS[i].eaTag, srcAValue, VECS[i].eaVal);
      checkPort("row srcB", int'(VECS[i].req), srcBTag, VECS[i].ebTag, srcBValue, VECS[i].ebVal);
    end

    // R1: reset mid-run clears a pending tag and stored values
    @(negedge clk);
    idle();
    issueValid = 1'b1; issueDest = 4'd1; issueTag = 4'd9;
    @(negedge clk);
    idle();
    srcA = 4'd1; srcB = 4'd4;
    #1;
    checkPort("pending before reset", 4, srcATag, 4'd9, srcAValue, 64'h0);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    #1;
    checkPort("after reset reg1", 1, srcATag, 4'd0, srcAValue, 64'h0);
    checkPort("after reset reg4", 1, srcBTag, 4'd0, srcBValue, 64'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule